// File: doc/BRIEF.md
# In-Order Load Return Sequencer

This block sits between the load issue stage and the integer register file write port. Every load that issues is recorded in a small circular queue together with its destination tag. It also records whether the data cache hit and which return timing applies to it. The block then hands loads back one at a time, strictly in the order they were accepted, on a single return path. Each return gives the destination tag and a marker that says whether the load used the slow timing.

A plain hit comes back two cycles after its issue cycle. A signed integer load narrower than 64 bits needs one more cycle. That signed load also switches the block into a delayed mode, in which every load accepted in the cycles right after it also takes three cycles. The delayed mode lasts until a cycle passes with no accepted load.

A miss waits for a fill-complete pulse from the miss handler. Because returns never overtake each other, a miss at the head of the queue holds back every younger load, including hits that are already ready. The cache arrays and the miss machinery are outside this block; it only sequences tags and timing.

Top module: `load_return_seq`

## Requirements
- R1: A non-signed load that hits and is not held back raises `retValid` with its tag exactly 2 cycles after the cycle in which it was presented on the issue inputs.
- R2: A signed narrow load (`issueSigned` = 1) that hits and is not held back returns exactly 3 cycles after its issue cycle.
- R3: Accepting a signed narrow load enters delayed mode. Every load accepted in the next cycle, and in each further back-to-back cycle, also uses the 3-cycle timing, even if it is not signed.
- R4: A cycle with no accepted load leaves delayed mode. A non-signed hit accepted after such a cycle returns in 2 cycles again.
- R5: Loads return in the order they were accepted. A hit that is younger than a pending miss returns no earlier than the cycle after that miss returns.
- R6: Fill pulses on `fillDone` serve the outstanding misses oldest first. A missed load returns no earlier than 2 cycles after the cycle of its fill pulse.
- R7: At most one load returns per cycle. A load that was held back returns in the first cycle that is both after the previous return and no earlier than its own ready cycle.
- R8: The queue holds DEPTH loads (8 by default), and `qFull` is high exactly while it holds DEPTH loads. A load presented while `qFull` is high is dropped: it never returns, and it counts as a cycle with no issue for delayed mode.
- R9: After reset, `retValid`, `retLate` and `qFull` are low and the queue is empty.
- R10: `retLate` is high together with `retValid` when the returning load used the 3-cycle timing. It is low when the load used the 2-cycle timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | A load is presented this cycle |
| issueSigned | input | 1 | The presented load is a signed integer load narrower than 64 bits |
| issueMiss | input | 1 | The presented load missed in the data cache |
| issueTag | input | TAG_W | Destination register tag of the presented load |
| fillDone | input | 1 | One outstanding miss (the oldest not yet filled) has its data |
| qFull | output | 1 | Queue holds DEPTH loads; a load presented now is dropped |
| retValid | output | 1 | A load returns this cycle |
| retTag | output | TAG_W | Destination tag of the returning load |
| retLate | output | 1 | The returning load used the delayed (3-cycle) timing |

## Verification
A corrupted head or tail pointer shows up within a few cycles as a tag leaving `retTag` out of issue order, or as a tag that was never issued. A wrong per-entry countdown moves a return one cycle early or late. The bench catches this at the cycle of that return, because every expected return cycle is computed from the issue and fill cycles. A wrong delayed-mode flag or fill credit count shows up as `retLate` wrong on the next return, or as a miss and every load behind it returning before its fill pulse.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  // Strobes from the control module to the datapath for one cycle.
  typedef struct packed {
    logic push;      // write the presented load into the tail slot
    logic pushLate;  // the pushed load takes the delayed timing
    logic pop;       // the head load returns at the next edge
  } ctrlStrobe_t;

endpackage

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
  import lrs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             issueSigned,
  input  logic             fillDone,
  input  logic             headWaitDone,
  input  logic             headMiss,
  output ctrlStrobe_t      strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             qFull
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] credit;   // fill pulses not yet consumed by a returning miss
  logic             lateMode;
  logic             accept;
  logic             headGo;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign qFull  = (count == CNT_W'(DEPTH));
  assign accept = issueValid && !qFull;
  assign headGo = (count != '0) && headWaitDone && (!headMiss || (credit != '0));

  always_comb begin
    strobe          = '0;
    strobe.push     = accept;
    strobe.pushLate = accept && (issueSigned || lateMode);
    strobe.pop      = headGo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      credit   <= '0;
      lateMode <= 1'b0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      count    <= count + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
      credit   <= credit + CNT_W'(fillDone) - CNT_W'(strobe.pop && headMiss);
      lateMode <= accept ? (lateMode || issueSigned) : 1'b0;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R8
  count_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (int'(count) == int'($past(count)) + int'($past(strobe.push))
                                     - int'($past(strobe.pop))));

  // R4
  late_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> !lateMode);

  // R3
  late_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueSigned && !qFull) |=> lateMode);

endmodule

// File: rtl/lrs_dpath.sv
module lrs_dpath
  import lrs_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int PTR_W        = 3,
  parameter int TAG_W        = 5,
  parameter int WAIT_W       = 2,
  parameter int HIT_LAT      = 2,
  parameter int SIGNED_EXTRA = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic [TAG_W-1:0] issueTag,
  input  logic             issueMiss,
  output logic             headWaitDone,
  output logic             headMiss,
  output logic             retValid,
  output logic [TAG_W-1:0] retTag,
  output logic             retLate
);

  // The countdown starts at the latency minus two: one cycle for the
  // issue edge and one for the registered return output.
  localparam int WAIT_FAST = HIT_LAT - 2;
  localparam int WAIT_SLOW = HIT_LAT + SIGNED_EXTRA - 2;

  logic [TAG_W-1:0]  tagVec  [DEPTH];
  logic [WAIT_W-1:0] waitVec [DEPTH];
  logic              missVec [DEPTH];
  logic              lateVec [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [TAG_W-1:0]  tagR;
    logic [WAIT_W-1:0] waitR;
    logic              missR;
    logic              lateR;
    logic              wrHere;

    assign wrHere = strobe.push && (wrPtr == PTR_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagR  <= '0;
        waitR <= '0;
        missR <= 1'b0;
        lateR <= 1'b0;
      end else if (wrHere) begin
        tagR  <= issueTag;
        missR <= issueMiss;
        lateR <= strobe.pushLate;
        waitR <= strobe.pushLate ? WAIT_W'(WAIT_SLOW) : WAIT_W'(WAIT_FAST);
      end else if (waitR != '0) begin
        waitR <= waitR - WAIT_W'(1);
      end
    end

    assign tagVec[i]  = tagR;
    assign waitVec[i] = waitR;
    assign missVec[i] = missR;
    assign lateVec[i] = lateR;
  end

  assign headWaitDone = (waitVec[rdPtr] == '0);
  assign headMiss     = missVec[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retValid <= 1'b0;
      retTag   <= '0;
      retLate  <= 1'b0;
    end else begin
      retValid <= strobe.pop;
      retLate  <= strobe.pop && lateVec[rdPtr];
      if (strobe.pop) retTag <= tagVec[rdPtr];
    end
  end

  // R1
  pop_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> headWaitDone);

  // R10
  late_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    retLate |-> retValid);

  // R7
  ret_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |=> retValid);

endmodule

// File: rtl/load_return_seq.sv
module load_return_seq
  import lrs_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int TAG_W        = 5,
  parameter int HIT_LAT      = 2,
  parameter int SIGNED_EXTRA = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             issueSigned,
  input  logic             issueMiss,
  input  logic [TAG_W-1:0] issueTag,
  input  logic             fillDone,
  output logic             qFull,
  output logic             retValid,
  output logic [TAG_W-1:0] retTag,
  output logic             retLate
);

  localparam int PTR_W  = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int SLOW   = HIT_LAT + SIGNED_EXTRA - 2;
  localparam int WAIT_W = (SLOW < 2) ? 1 : $clog2(SLOW + 1);

  ctrlStrobe_t      strobe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             headWaitDone;
  logic             headMiss;

  lrs_ctrl #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .issueValid   (issueValid),
    .issueSigned  (issueSigned),
    .fillDone     (fillDone),
    .headWaitDone (headWaitDone),
    .headMiss     (headMiss),
    .strobe       (strobe),
    .wrPtr        (wrPtr),
    .rdPtr        (rdPtr),
    .qFull        (qFull)
  );

  lrs_dpath #(
    .DEPTH        (DEPTH),
    .PTR_W        (PTR_W),
    .TAG_W        (TAG_W),
    .WAIT_W       (WAIT_W),
    .HIT_LAT      (HIT_LAT),
    .SIGNED_EXTRA (SIGNED_EXTRA)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrPtr        (wrPtr),
    .rdPtr        (rdPtr),
    .issueTag     (issueTag),
    .issueMiss    (issueMiss),
    .headWaitDone (headWaitDone),
    .headMiss     (headMiss),
    .retValid     (retValid),
    .retTag       (retTag),
    .retLate      (retLate)
  );

endmodule

// File: tb/load_return_seq_tb.sv
module load_return_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int TAG_W      = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             issueValid = 1'b0;
  logic             issueSigned = 1'b0;
  logic             issueMiss = 1'b0;
  logic [TAG_W-1:0] issueTag = '0;
  logic             fillDone = 1'b0;
  logic             qFull;
  logic             retValid;
  logic [TAG_W-1:0] retTag;
  logic             retLate;

  load_return_seq #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueSigned(issueSigned),
    .issueMiss(issueMiss), .issueTag(issueTag), .fillDone(fillDone),
    .qFull(qFull), .retValid(retValid), .retTag(retTag), .retLate(retLate)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [TAG_W-1:0] tag;
    logic             late;
    int               cyc;
    string            req;
  } expItem_t;

  expItem_t expQ[$];
  int       fillQ[$];
  int       expList[$];
  int       cyc = 0;
  int       tests = 0;
  int       fails = 0;
  int       lastRet = -1;
  bit       chain = 1'b0;
  bit       running = 1'b0;
  bit       done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int occupancy(input int c);
    int n = 0;
    foreach (expList[k]) if (expList[k] > c) n++;
    return n;
  endfunction

  // Driver: present one load in the next cycle and push its expected return.
  task automatic issueLoad(input logic [TAG_W-1:0] tag, input bit sgn, input bit miss,
                           input int fillDelay, input string req);
    int c, occ, lat, ready, exp;
    expItem_t it;
    @(negedge clk);
    c   = cyc;
    occ = occupancy(c);
    check(qFull == (occ == DEPTH), "R8", "qFull", int'(qFull), int'(occ == DEPTH));
    issueValid  = 1'b1;
    issueSigned = sgn;
    issueMiss   = miss;
    issueTag    = tag;
    if (occ < DEPTH) begin
      lat   = (sgn || chain) ? 3 : 2;
      ready = c + lat;
      if (miss) begin
        fillQ.push_back(c + fillDelay);
        if (c + fillDelay + 2 > ready) ready = c + fillDelay + 2;
      end
      exp = (ready > lastRet + 1) ? ready : lastRet + 1;
      lastRet = exp;
      it.tag = tag; it.late = (lat == 3); it.cyc = exp; it.req = req;
      expQ.push_back(it);
      expList.push_back(exp);
      chain = chain || sgn;
    end else begin
      chain = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      issueValid  = 1'b0;
      issueSigned = 1'b0;
      issueMiss   = 1'b0;
      chain       = 1'b0;
    end
  endtask

  // Fill pulses at the scheduled cycles.
  always @(negedge clk) begin
    fillDone = 1'b0;
    if (fillQ.size() > 0 && fillQ[0] == cyc) begin
      fillDone = 1'b1;
      void'(fillQ.pop_front());
    end
  end

  // Monitor: compare each return against the scoreboard.
  always @(negedge clk) begin
    if (running) begin
      if (retValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7", "unexpected return tag", int'(retTag), -1);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(retTag == it.tag, it.req, "return tag", int'(retTag), int'(it.tag));
          check(retLate == it.late, {it.req, " R10"}, "retLate", int'(retLate), int'(it.late));
          check(cyc == it.cyc, it.req, "return cycle", cyc, it.cyc);
        end
      end else if (expQ.size() > 0 && expQ[0].cyc <= cyc) begin
        expItem_t it;
        it = expQ.pop_front();
        check(1'b0, it.req, "missing return of tag", -1, int'(it.tag));
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: state while held in reset
    check(!retValid && !retLate && !qFull, "R9", "outputs in reset",
          int'({retValid, retLate, qFull}), 0);
    rstN = 1'b1;
    running = 1'b1;
    idle(2);
    check(!retValid && !retLate && !qFull, "R9", "outputs after reset",
          int'({retValid, retLate, qFull}), 0);

    // R1: plain hit
    issueLoad(5'd1, 1'b0, 1'b0, 0, "R1");
    idle(5);
    // R2: signed narrow hit
    issueLoad(5'd2, 1'b1, 1'b0, 0, "R2");
    idle(5);
    // R3: delayed mode carries over back-to-back loads; R4: gap ends it
    issueLoad(5'd3, 1'b1, 1'b0, 0, "R3");
    issueLoad(5'd4, 1'b0, 1'b0, 0, "R3");
    issueLoad(5'd5, 1'b0, 1'b0, 0, "R3");
    idle(1);
    issueLoad(5'd6, 1'b0, 1'b0, 0, "R4");
    idle(5);
    // R10: plain then signed then plain inside the mode
    issueLoad(5'd7, 1'b0, 1'b0, 0, "R10");
    issueLoad(5'd8, 1'b1, 1'b0, 0, "R10");
    issueLoad(5'd9, 1'b0, 1'b0, 0, "R3");
    idle(5);
    // R5/R6: a miss holds back three younger hits
    issueLoad(5'd10, 1'b0, 1'b1, 8, "R6");
    issueLoad(5'd11, 1'b0, 1'b0, 0, "R5");
    issueLoad(5'd12, 1'b1, 1'b0, 0, "R5");
    issueLoad(5'd13, 1'b0, 1'b0, 0, "R5");
    idle(15);
    // R6: two misses, fills served oldest first
    issueLoad(5'd14, 1'b0, 1'b1, 4, "R6");
    issueLoad(5'd15, 1'b0, 1'b1, 6, "R6");
    idle(12);
    // R7: stream of hits, one return per cycle
    for (int k = 0; k < 6; k++) issueLoad(TAG_W'(16 + k), 1'b0, 1'b0, 0, "R7");
    idle(10);
    // R8: fill the queue with misses, then present two loads that are dropped
    for (int k = 0; k < DEPTH; k++) issueLoad(TAG_W'(22 + k), 1'b0, 1'b1, 20, "R8");
    issueLoad(5'd30, 1'b1, 1'b0, 0, "R8");
    issueLoad(5'd31, 1'b0, 1'b0, 0, "R8");
    idle(40);
    // R8: a hit after the drain takes normal timing
    issueLoad(5'd0, 1'b0, 1'b0, 0, "R8");
    idle(20);

    check(expQ.size() == 0, "R5", "returns still pending", expQ.size(), 0);
    check(fillQ.size() == 0, "R6", "fills still pending", fillQ.size(), 0);
    finishRun();
  end

endmodule